// File: doc/BRIEF.md
# Power-Down Entry and Wake Controller

This block sequences a chip-wide low-power mode. Software programs a small control word that holds the oscillator enables, a power-down request, an entry mode that can wait for the processor to reach sleep, a wake-delay enable and a wake interrupt enable. Once the request is honoured, the block drops the high-speed oscillator enables, the PLL enable and the system clock enable. The low-speed oscillators keep running. Any peripheral wake event ends the low-power state.

On wake the block clears the request, so software must set it again for the next entry. It sets a sticky wake flag, which can feed an interrupt. It can also hold the system clock off for a stabilisation window. That window is 4096 cycles when the system runs from the high-speed crystal and 256 cycles when it runs from the high-speed RC oscillator. Every control bit except the wake flag is guarded: it can only be written after a three-byte key sequence has been written to a separate key address.

The register port has two addresses: the control word at address 0 and the key register at address 1. The control word is visible at all times on `ctrl_rdata`.

Top module: `pdwake_ctrl`

## Requirements
- R1: Control bits 0-6, 8 and 9 change on a write to address 0 only while the key gate is open. The gate opens after the bytes 0x59, 0x16 and 0x88 are written to address 1 in that order. Bit 15 of `ctrl_rdata` reads 1 while the gate is open.
- R2: A wrong byte anywhere in the key sequence leaves the gate closed. Any write to address 1 while the gate is open closes it again.
- R3: With bit 8 (power-down request) at 1 and bit 9 (wait-for-sleep) at 0, the block enters power-down on the next clock edge.
- R4: With bit 9 at 1, the block stays running while `cpu_sleep` is 0. It enters power-down on the edge at which `cpu_sleep` is 1 together with bit 8.
- R5: In power-down, `hxt_en`, `hirc_en`, `pll_en` and `sysclk_en` are 0. `lxt_en` and `lirc_en` keep following bits 3 and 4. Outside power-down, `hxt_en`, `hirc_en` and `pll_en` follow bits 0, 1 and 2.
- R6: A wake event seen in power-down ends it and clears bit 8 in hardware.
- R7: A wake event on any line of `wake_evt` sets bit 7 (wake flag) while in power-down. A wake event outside power-down leaves bit 7 unchanged. Writing 1 to bit 7 clears it, and this does not depend on the key gate.
- R8: `wake_irq` is 1 exactly when bit 7 and bit 6 (interrupt enable) are both 1.
- R9: With bit 5 (wake delay) at 1, `sysclk_en` stays 0 for 4096 cycles after the wake edge when `src_rc` is 0, and for 256 cycles when `src_rc` is 1. It rises on the cycle after the counter's terminal count. The high-speed oscillator enables are on again throughout the delay.
- R10: With bit 5 at 0, `sysclk_en` is 1 in the cycle right after the edge that samples the wake event.
- R11: After reset the control word reads 0x0002 (only the high-speed RC enable is set), the gate is closed and the block is running.

Unlisted bits of the control word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (selected source clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 control word, 1 key register |
| wr_data | input | 16 | Write data |
| cpu_sleep | input | 1 | Processor has executed its sleep instruction |
| wake_evt | input | WAKE_N | Peripheral wake event lines |
| src_rc | input | 1 | System clock runs from high-speed RC (1) or crystal (0) |
| hxt_en | output | 1 | High-speed crystal enable |
| hirc_en | output | 1 | High-speed RC oscillator enable |
| pll_en | output | 1 | PLL enable |
| lxt_en | output | 1 | Low-speed crystal enable |
| lirc_en | output | 1 | Low-speed RC oscillator enable |
| sysclk_en | output | 1 | System clock gate enable |
| wake_irq | output | 1 | Wake interrupt |
| ctrl_rdata | output | 16 | Control word read-back, bit 15 gate open |

## Verification
The key gate is driven with the correct sequence and with a wrong byte placed at each of the three positions in turn. This separates an in-order comparator from one that checks only the final byte or ignores order. The wake lines are swept one at a time, alternating immediate and wait-for-sleep entry, so a missing line in the wake reduction or a broken entry mode shows up on a specific step. The delay window is measured on the cycle before and the cycle of release for both clock sources, which catches off-by-one errors and swapped counts. Interrupt checks cover flag and enable set together, each set alone, and the flag cleared by a write of 1.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_PD   = 2'd1,
    SEQ_WAKE = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_ONE  = 2'd1,
    KEY_TWO  = 2'd2,
    KEY_OPEN = 2'd3
  } key_state_e;

  localparam logic [7:0] KEY_B0 = 8'h59;
  localparam logic [7:0] KEY_B1 = 8'h16;
  localparam logic [7:0] KEY_B2 = 8'h88;

  localparam int F_HXT   = 0;
  localparam int F_HIRC  = 1;
  localparam int F_PLL   = 2;
  localparam int F_LXT   = 3;
  localparam int F_LIRC  = 4;
  localparam int F_DLY   = 5;
  localparam int F_IRQEN = 6;
  localparam int F_FLAG  = 7;
  localparam int F_PDREQ = 8;
  localparam int F_WAIT  = 9;
  localparam int F_OPEN  = 15;

  typedef struct packed {
    logic wait_cpu;
    logic irq_en;
    logic dly_en;
    logic lirc_on;
    logic lxt_on;
    logic pll_on;
    logic hirc_on;
    logic hxt_on;
  } pdw_cfg_t;

  localparam pdw_cfg_t CFG_RESET = '{hirc_on: 1'b1, default: 1'b0};

endpackage

// File: rtl/pdw_key_gate.sv
module pdw_key_gate
  import pdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       gate_open
);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      unique case (state_q)
        KEY_IDLE: state_d = (key_byte == KEY_B0) ? KEY_ONE  : KEY_IDLE;
        KEY_ONE:  state_d = (key_byte == KEY_B1) ? KEY_TWO  :
                            (key_byte == KEY_B0) ? KEY_ONE  : KEY_IDLE;
        KEY_TWO:  state_d = (key_byte == KEY_B2) ? KEY_OPEN :
                            (key_byte == KEY_B0) ? KEY_ONE  : KEY_IDLE;
        KEY_OPEN: state_d = KEY_IDLE;
        default:  state_d = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else if (key_wr) state_q <= state_d;
  end

  assign gate_open = (state_q == KEY_OPEN);

  assert_open_in_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KEY_OPEN) |-> ($past(state_q) == KEY_TWO || $past(state_q) == KEY_OPEN));

  assert_open_relocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && state_q == KEY_OPEN) |=> (state_q == KEY_IDLE));

endmodule

// File: rtl/pdw_ctrl_regs.sv
module pdw_ctrl_regs
  import pdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [15:0] wdata,
  input  logic        gate_open,
  input  logic        wake_set,
  input  logic        pd_clr,
  output pdw_cfg_t    cfg,
  output logic        pd_req,
  output logic        wake_flag,
  output logic [15:0] rdata
);

  pdw_cfg_t cfg_q, cfg_d;
  logic     pd_req_q, pd_req_d;
  logic     flag_q, flag_d;
  logic     prot_wr;
  logic     unused_wbits;

  assign prot_wr      = ctrl_wr && gate_open;
  assign unused_wbits = ^wdata[15:10];

  always_comb begin
    cfg_d = cfg_q;
    if (prot_wr) begin
      cfg_d.hxt_on   = wdata[F_HXT];
      cfg_d.hirc_on  = wdata[F_HIRC];
      cfg_d.pll_on   = wdata[F_PLL];
      cfg_d.lxt_on   = wdata[F_LXT];
      cfg_d.lirc_on  = wdata[F_LIRC];
      cfg_d.dly_en   = wdata[F_DLY];
      cfg_d.irq_en   = wdata[F_IRQEN];
      cfg_d.wait_cpu = wdata[F_WAIT];
    end
  end

  always_comb begin
    pd_req_d = pd_req_q;
    if (pd_clr)       pd_req_d = 1'b0;
    else if (prot_wr) pd_req_d = wdata[F_PDREQ];
  end

  always_comb begin
    flag_d = flag_q;
    if (wake_set)                     flag_d = 1'b1;
    else if (ctrl_wr && wdata[F_FLAG]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RESET;
      pd_req_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (prot_wr)                       cfg_q    <= cfg_d;
      if (pd_clr || prot_wr)             pd_req_q <= pd_req_d;
      if (wake_set || ctrl_wr)           flag_q   <= flag_d;
    end
  end

  assign cfg       = cfg_q;
  assign pd_req    = pd_req_q;
  assign wake_flag = flag_q;

  always_comb begin
    rdata          = '0;
    rdata[F_HXT]   = cfg_q.hxt_on;
    rdata[F_HIRC]  = cfg_q.hirc_on;
    rdata[F_PLL]   = cfg_q.pll_on;
    rdata[F_LXT]   = cfg_q.lxt_on;
    rdata[F_LIRC]  = cfg_q.lirc_on;
    rdata[F_DLY]   = cfg_q.dly_en;
    rdata[F_IRQEN] = cfg_q.irq_en;
    rdata[F_FLAG]  = flag_q;
    rdata[F_PDREQ] = pd_req_q;
    rdata[F_WAIT]  = cfg_q.wait_cpu;
    rdata[F_OPEN]  = gate_open;
  end

  assert_locked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !gate_open) |=> $stable(cfg_q));

  assert_req_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_clr |=> !pd_req_q);

  assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> flag_q);

endmodule

// File: rtl/pdw_wake_seq.sv
module pdw_wake_seq
  import pdw_pkg::*;
#(
  parameter int DLY_XTAL = 4096,
  parameter int DLY_RC   = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req,
  input  logic       wait_cpu,
  input  logic       cpu_sleep,
  input  logic       wake_any,
  input  logic       dly_en,
  input  logic       src_rc,
  output seq_state_e state,
  output logic       wake_hit
);

  localparam int DLY_MAX = (DLY_XTAL > DLY_RC) ? DLY_XTAL : DLY_RC;
  localparam int CNT_W   = $clog2(DLY_MAX) + 1;
  localparam logic [CNT_W-1:0] LOAD_XTAL = CNT_W'(DLY_XTAL - 1);
  localparam logic [CNT_W-1:0] LOAD_RC   = CNT_W'(DLY_RC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SEQ_RUN: begin
        if (pd_req && (!wait_cpu || cpu_sleep)) state_d = SEQ_PD;
      end
      SEQ_PD: begin
        if (wake_any) begin
          if (dly_en) begin
            state_d = SEQ_WAKE;
            cnt_d   = src_rc ? LOAD_RC : LOAD_XTAL;
            cnt_en  = 1'b1;
          end else begin
            state_d = SEQ_RUN;
          end
        end
      end
      SEQ_WAKE: begin
        if (cnt_q == '0) begin
          state_d = SEQ_RUN;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state    = state_q;
  assign wake_hit = (state_q == SEQ_PD) && wake_any;

  assert_enter_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && pd_req && !wait_cpu) |=> (state_q == SEQ_PD));

  assert_wait_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && wait_cpu && !cpu_sleep) |=> (state_q == SEQ_RUN));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAKE) |-> (cnt_q < CNT_W'(DLY_MAX)));

  assert_no_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_PD && wake_any && !dly_en) |=> (state_q == SEQ_RUN));

endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
  import pdw_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int WAKE_N   = 8,
  parameter int DLY_XTAL = 4096,
  parameter int DLY_RC   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              cpu_sleep,
  input  logic [WAKE_N-1:0] wake_evt,
  input  logic              src_rc,
  output logic              hxt_en,
  output logic              hirc_en,
  output logic              pll_en,
  output logic              lxt_en,
  output logic              lirc_en,
  output logic              sysclk_en,
  output logic              wake_irq,
  output logic [15:0]       ctrl_rdata
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(1);

  logic       ctrl_wr, key_wr, gate_open;
  logic       pd_req, wake_flag, wake_hit, wake_any;
  pdw_cfg_t   cfg;
  seq_state_e state;

  assign ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR);
  assign key_wr   = wr_en && (wr_addr == KEY_ADDR);
  assign wake_any = |wake_evt;

  pdw_key_gate u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (key_wr),
    .key_byte  (wr_data[7:0]),
    .gate_open (gate_open)
  );

  pdw_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .wdata     (wr_data),
    .gate_open (gate_open),
    .wake_set  (wake_hit),
    .pd_clr    (wake_hit),
    .cfg       (cfg),
    .pd_req    (pd_req),
    .wake_flag (wake_flag),
    .rdata     (ctrl_rdata)
  );

  pdw_wake_seq #(
    .DLY_XTAL (DLY_XTAL),
    .DLY_RC   (DLY_RC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_req    (pd_req),
    .wait_cpu  (cfg.wait_cpu),
    .cpu_sleep (cpu_sleep),
    .wake_any  (wake_any),
    .dly_en    (cfg.dly_en),
    .src_rc    (src_rc),
    .state     (state),
    .wake_hit  (wake_hit)
  );

  logic fast_ok;
  assign fast_ok   = (state != SEQ_PD);
  assign hxt_en    = cfg.hxt_on  && fast_ok;
  assign hirc_en   = cfg.hirc_on && fast_ok;
  assign pll_en    = cfg.pll_on  && fast_ok;
  assign lxt_en    = cfg.lxt_on;
  assign lirc_en   = cfg.lirc_on;
  assign sysclk_en = (state == SEQ_RUN);
  assign wake_irq  = wake_flag && cfg.irq_en;

  assert_pd_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_PD) |-> (!sysclk_en && !hxt_en && !hirc_en && !pll_en));

  assert_irq_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (ctrl_rdata[F_FLAG] && ctrl_rdata[F_IRQEN]));

  assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_PD && wake_any) |=> (!ctrl_rdata[F_PDREQ] && ctrl_rdata[F_FLAG]));

endmodule

// File: tb/test_pdwake_ctrl.sv
module test_pdwake_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 2;
  localparam int WAKE_N     = 8;
  localparam int DLY_XTAL   = 4096;
  localparam int DLY_RC     = 256;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [15:0]       wr_data;
  logic              cpu_sleep;
  logic [WAKE_N-1:0] wake_evt;
  logic              src_rc;
  logic hxt_en, hirc_en, pll_en, lxt_en, lirc_en, sysclk_en, wake_irq;
  logic [15:0]       ctrl_rdata;

  int n_vec  = 0;
  int n_miss = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdwake_ctrl #(
    .ADDR_W (ADDR_W), .WAKE_N (WAKE_N), .DLY_XTAL (DLY_XTAL), .DLY_RC (DLY_RC)
  ) i_pdwake_ctrl (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .cpu_sleep (cpu_sleep), .wake_evt (wake_evt),
    .src_rc (src_rc), .hxt_en (hxt_en), .hirc_en (hirc_en), .pll_en (pll_en),
    .lxt_en (lxt_en), .lirc_en (lirc_en), .sysclk_en (sysclk_en),
    .wake_irq (wake_irq), .ctrl_rdata (ctrl_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic open_gate();
    wr(1, 16'h0059); wr(1, 16'h0016); wr(1, 16'h0088);
  endtask

  task automatic pulse_wake(input int line);
    @(negedge clk);
    wake_evt = WAKE_N'(1) << line;
    @(negedge clk);
    wake_evt = '0;
  endtask

  // packed view {sysclk, hxt, hirc, pll, lxt, lirc}
  function automatic logic [5:0] outs();
    return {sysclk_en, hxt_en, hirc_en, pll_en, lxt_en, lirc_en};
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_vec++; n_miss++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cpu_sleep = 1'b0; wake_evt = '0; src_rc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 ctrl", ctrl_rdata, 16'h0002);
    check("R11 outs", outs(), 6'b101000);
    check("R11 irq", wake_irq, 0);

    // R1 locked write ignored
    wr(0, 16'h037F);
    check("R1 locked", ctrl_rdata, 16'h0002);
    @(negedge clk);
    check("R1 locked run", sysclk_en, 1);

    // R2 a wrong byte at each position keeps the gate shut
    for (int p = 0; p < 3; p++) begin
      wr(1, (p == 0) ? 16'h0000 : 16'h0059);
      wr(1, (p == 1) ? 16'h0000 : 16'h0016);
      wr(1, (p == 2) ? 16'h0000 : 16'h0088);
      check("R2 bad key", ctrl_rdata[15], 0);
    end

    open_gate();
    check("R1 open", ctrl_rdata[15], 1);
    wr(1, 16'h0059);
    check("R2 relock", ctrl_rdata[15], 0);
    open_gate();
    wr(0, 16'h001F);
    check("R1 write", ctrl_rdata, 16'h801F);

    // R7 wake outside power-down ignored
    @(negedge clk); wake_evt = '1;
    @(negedge clk); wake_evt = '0;
    check("R7 idle wake", ctrl_rdata[7], 0);
    check("R7 idle run", sysclk_en, 1);

    // sweep wake lines, alternating entry mode
    for (int i = 0; i < WAKE_N; i++) begin
      logic w;
      w = i[0];
      wr(0, 16'h011F | (16'(w) << 9));
      if (w) begin
        repeat (3) @(negedge clk);
        check("R4 waits", outs(), 6'b111111);
        cpu_sleep = 1'b1;
        @(negedge clk);
        cpu_sleep = 1'b0;
        check("R4 enter", outs(), 6'b000011);
      end else begin
        @(negedge clk);
        check("R3 enter", outs(), 6'b000011);
      end
      pulse_wake(i);
      check("R10 resume", outs(), 6'b111111);
      check("R6 req cleared", ctrl_rdata[8], 0);
      check("R7 flag set", ctrl_rdata[7], 1);
      wr(0, 16'h009F);
      check("R7 flag clear", ctrl_rdata[7], 0);
    end

    // R9 delay for both sources, with interrupt
    for (int s = 1; s >= 0; s--) begin
      int n;
      n = (s == 1) ? DLY_RC : DLY_XTAL;
      src_rc = s[0];
      wr(0, 16'h017F);
      @(negedge clk);
      check("R5 pd", outs(), 6'b000011);
      pulse_wake(s + 2);
      check("R9 held, osc on", outs(), 6'b011111);
      repeat (n - 1) @(negedge clk);
      check("R9 last held", sysclk_en, 0);
      @(negedge clk);
      check("R9 release", sysclk_en, 1);
      check("R8 irq on", wake_irq, 1);
      wr(0, 16'h00FF);
      check("R8 irq cleared", wake_irq, 0);
    end

    // R8 flag without enable
    wr(0, 16'h011F);
    @(negedge clk);
    pulse_wake(5);
    check("R8 flag only", ctrl_rdata[7], 1);
    check("R8 no irq", wake_irq, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule